// File: doc/BRIEF.md
# Local Interrupt Priority Selector

This block decides which local interrupt line a hart should take next, at machine or supervisor level. It keeps three state words, each one bit per line: a pending word, an enable word and a delegation word. A line is a candidate when it is both pending and enabled. Candidates that are not delegated pass only while machine-level interrupts are globally open. Delegated candidates pass only while supervisor-level interrupts are globally open. Whether each level is open depends on the current privilege level and that level's interrupt-enable input. Among the lines that pass, the lowest-numbered one wins. Its index and a valid flag are registered.

The pending word is changed through a masked write. Bits selected by the mask take the supplied value and the other bits keep their old value. The pending word is always visible on an output, so the value seen in the cycle of a write is the value that the write replaces.

A claim word lets external sources reserve lines. A claim request either succeeds and adds its lines to the claim word, or is refused in full when any requested line is already reserved. The outcome is reported one cycle later.

Top module: `irq_sel_top`

## Requirements
- R1: An active-low asynchronous reset clears the pending, enable, delegation and claim words, and drives irqValid, irqIndex, claimDone and claimFail to zero.
- R2: When pendWrEn is high at a rising edge, each pending bit whose pendWrMask bit is 1 takes pendWrVal, and each bit whose mask bit is 0 keeps its value. When pendWrEn is low the word is unchanged. pendOld always shows the current pending word, so in the write cycle it shows the value being replaced.
- R3: A line is a candidate only when its pending bit and its enable bit are both 1. A pending line whose enable bit is 0 is never selected.
- R4: The privilege input privLvl is 2 bits wide: user is 0, supervisor is 1, machine is 3. A candidate whose delegation bit is 0 passes when privLvl is not 3, or when privLvl is 3 and mIe is 1.
- R5: A candidate whose delegation bit is 1 passes only when privLvl is 0, or when privLvl is 1 and sIe is 1. At privLvl 2 or 3 it never passes.
- R6: When any line passes, irqValid is 1 and irqIndex is the lowest-numbered passing line. When none passes, irqValid is 0 and irqIndex is 0.
- R7: irqValid and irqIndex are registered. They reflect the state words and the privLvl, mIe and sIe inputs as held at the previous rising edge. A change in state therefore reaches them one edge after the state register itself changes.
- R8: A claim request (claimReq high) whose claimLines overlap the claim word is refused and leaves the word unchanged. A request with no overlap ORs claimLines into the word. On the next edge claimDone is 1 for one cycle, and claimFail is 1 only for a refused request.
- R9: enWrEn loads enWrVal into the enable word in full. delegWrEn loads delegWrVal into the delegation word in full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| pendWrEn | input | 1 | Masked write to the pending word |
| pendWrMask | input | NUM_LINES | Bits that the write may change |
| pendWrVal | input | NUM_LINES | New values for the masked bits |
| pendOld | output | NUM_LINES | Current pending word |
| enWrEn | input | 1 | Load the enable word |
| enWrVal | input | NUM_LINES | New enable word |
| delegWrEn | input | 1 | Load the delegation word |
| delegWrVal | input | NUM_LINES | New delegation word |
| privLvl | input | 2 | Current privilege level (0 user, 1 supervisor, 3 machine) |
| mIe | input | 1 | Machine-level global interrupt enable |
| sIe | input | 1 | Supervisor-level global interrupt enable |
| claimReq | input | 1 | Claim request strobe |
| claimLines | input | NUM_LINES | Lines to reserve |
| claimDone | output | 1 | A claim was processed in the previous cycle |
| claimFail | output | 1 | The processed claim was refused |
| claimedOut | output | NUM_LINES | Current claim word |
| irqValid | output | 1 | An interrupt is selected |
| irqIndex | output | IDX_W | Index of the selected line |

## Verification
A wrong pending bit appears on pendOld in the cycle after the write. Through irqIndex it appears one edge later still, provided the line is enabled and its level is open. Enable and delegation faults stay hidden until a pending line exposes them, so the stimulus pairs each gating case with pending bits on both sides of the delegation split. A corrupted claim word appears at once on claimedOut. It also shows up on the next overlapping request as a wrong claimFail.

// File: rtl/irq_sel_pkg.sv
package irq_sel_pkg;

  typedef enum logic [1:0] {
    PRIV_USER  = 2'd0,
    PRIV_SUPER = 2'd1,
    PRIV_RSVD  = 2'd2,
    PRIV_MACH  = 2'd3
  } privLvl_e;

  // strobes from control to datapath
  typedef struct packed {
    logic pendWr;
    logic enWr;
    logic delegWr;
    logic claimTry;
    logic mAllow;
    logic sAllow;
  } ctrlStrobes_t;

endpackage

// File: rtl/irq_sel_ctrl.sv
module irq_sel_ctrl
  import irq_sel_pkg::*;
(
  input  logic         pendWrEn,
  input  logic         enWrEn,
  input  logic         delegWrEn,
  input  logic         claimReq,
  input  logic [1:0]   privLvl,
  input  logic         mIe,
  input  logic         sIe,
  output ctrlStrobes_t strobes
);

  privLvl_e curPriv;
  logic     machOpen;
  logic     superOpen;

  assign curPriv = privLvl_e'(privLvl);

  // lower privilege always admits higher-level interrupts
  always_comb begin
    machOpen  = 1'b0;
    superOpen = 1'b0;
    unique case (curPriv)
      PRIV_USER: begin
        machOpen  = 1'b1;
        superOpen = 1'b1;
      end
      PRIV_SUPER: begin
        machOpen  = 1'b1;
        superOpen = sIe;
      end
      PRIV_RSVD: begin
        machOpen  = 1'b1;
        superOpen = 1'b0;
      end
      PRIV_MACH: begin
        machOpen  = mIe;
        superOpen = 1'b0;
      end
      default: begin
        machOpen  = 1'b0;
        superOpen = 1'b0;
      end
    endcase
  end

  always_comb begin
    strobes.pendWr   = pendWrEn;
    strobes.enWr     = enWrEn;
    strobes.delegWr  = delegWrEn;
    strobes.claimTry = claimReq;
    strobes.mAllow   = machOpen;
    strobes.sAllow   = superOpen;
  end

endmodule

// File: rtl/irq_sel_prienc.sv
module irq_sel_prienc #(
  parameter int NUM_LINES = 32,
  parameter int IDX_W     = $clog2(NUM_LINES)
) (
  input  logic [NUM_LINES-1:0] reqVec,
  output logic                 anyHit,
  output logic [IDX_W-1:0]     hitIdx
);

  // scan from the top so the lowest set bit is written last
  always_comb begin
    anyHit = 1'b0;
    hitIdx = '0;
    for (int i = NUM_LINES - 1; i >= 0; i--) begin
      if (reqVec[i]) begin
        anyHit = 1'b1;
        hitIdx = IDX_W'(i);
      end
    end
  end

endmodule

// File: rtl/irq_sel_dp.sv
module irq_sel_dp
  import irq_sel_pkg::*;
#(
  parameter int NUM_LINES = 32,
  parameter int IDX_W     = $clog2(NUM_LINES)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ctrlStrobes_t         strobes,
  input  logic [NUM_LINES-1:0] pendWrMask,
  input  logic [NUM_LINES-1:0] pendWrVal,
  input  logic [NUM_LINES-1:0] enWrVal,
  input  logic [NUM_LINES-1:0] delegWrVal,
  input  logic [NUM_LINES-1:0] claimLines,
  output logic [NUM_LINES-1:0] pendOld,
  output logic [NUM_LINES-1:0] claimedOut,
  output logic                 claimDone,
  output logic                 claimFail,
  output logic                 irqValid,
  output logic [IDX_W-1:0]     irqIndex
);

  logic [NUM_LINES-1:0] pendReg;
  logic [NUM_LINES-1:0] enReg;
  logic [NUM_LINES-1:0] delegReg;
  logic [NUM_LINES-1:0] claimReg;
  logic [NUM_LINES-1:0] gatedVec;
  logic                 claimClash;
  logic                 selHit;
  logic [IDX_W-1:0]     selIdx;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendReg <= '0;
    end else if (strobes.pendWr) begin
      pendReg <= (pendReg & ~pendWrMask) | (pendWrVal & pendWrMask);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enReg    <= '0;
      delegReg <= '0;
    end else begin
      if (strobes.enWr)    enReg    <= enWrVal;
      if (strobes.delegWr) delegReg <= delegWrVal;
    end
  end

  assign claimClash = |(claimReg & claimLines);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      claimReg  <= '0;
      claimDone <= 1'b0;
      claimFail <= 1'b0;
    end else begin
      claimDone <= strobes.claimTry;
      claimFail <= strobes.claimTry & claimClash;
      if (strobes.claimTry && !claimClash) begin
        claimReg <= claimReg | claimLines;
      end
    end
  end

  // per-line gating by delegation target
  for (genvar g = 0; g < NUM_LINES; g++) begin : gLine
    logic levelOpen;
    assign levelOpen   = delegReg[g] ? strobes.sAllow : strobes.mAllow;
    assign gatedVec[g] = pendReg[g] & enReg[g] & levelOpen;
  end

  irq_sel_prienc #(
    .NUM_LINES(NUM_LINES),
    .IDX_W    (IDX_W)
  ) uPrienc (
    .reqVec(gatedVec),
    .anyHit(selHit),
    .hitIdx(selIdx)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irqValid <= 1'b0;
      irqIndex <= '0;
    end else begin
      irqValid <= selHit;
      irqIndex <= selHit ? selIdx : '0;
    end
  end

  assign pendOld    = pendReg;
  assign claimedOut = claimReg;

endmodule

// File: rtl/irq_sel_top.sv
module irq_sel_top
  import irq_sel_pkg::*;
#(
  parameter int NUM_LINES = 32,
  parameter int IDX_W     = $clog2(NUM_LINES)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 pendWrEn,
  input  logic [NUM_LINES-1:0] pendWrMask,
  input  logic [NUM_LINES-1:0] pendWrVal,
  output logic [NUM_LINES-1:0] pendOld,
  input  logic                 enWrEn,
  input  logic [NUM_LINES-1:0] enWrVal,
  input  logic                 delegWrEn,
  input  logic [NUM_LINES-1:0] delegWrVal,
  input  logic [1:0]           privLvl,
  input  logic                 mIe,
  input  logic                 sIe,
  input  logic                 claimReq,
  input  logic [NUM_LINES-1:0] claimLines,
  output logic                 claimDone,
  output logic                 claimFail,
  output logic [NUM_LINES-1:0] claimedOut,
  output logic                 irqValid,
  output logic [IDX_W-1:0]     irqIndex
);

  ctrlStrobes_t strobes;

  irq_sel_ctrl uCtrl (
    .pendWrEn (pendWrEn),
    .enWrEn   (enWrEn),
    .delegWrEn(delegWrEn),
    .claimReq (claimReq),
    .privLvl  (privLvl),
    .mIe      (mIe),
    .sIe      (sIe),
    .strobes  (strobes)
  );

  irq_sel_dp #(
    .NUM_LINES(NUM_LINES),
    .IDX_W    (IDX_W)
  ) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .pendWrMask(pendWrMask),
    .pendWrVal (pendWrVal),
    .enWrVal   (enWrVal),
    .delegWrVal(delegWrVal),
    .claimLines(claimLines),
    .pendOld   (pendOld),
    .claimedOut(claimedOut),
    .claimDone (claimDone),
    .claimFail (claimFail),
    .irqValid  (irqValid),
    .irqIndex  (irqIndex)
  );

endmodule

// File: rtl/irq_sel_chk.sv
module irq_sel_chk #(
  parameter int NUM_LINES = 32,
  parameter int IDX_W     = $clog2(NUM_LINES)
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 pendWrEn,
  input logic [NUM_LINES-1:0] pendWrMask,
  input logic [NUM_LINES-1:0] pendWrVal,
  input logic [NUM_LINES-1:0] pendOld,
  input logic                 claimReq,
  input logic [NUM_LINES-1:0] claimLines,
  input logic                 claimDone,
  input logic                 claimFail,
  input logic [NUM_LINES-1:0] claimedOut,
  input logic                 irqValid,
  input logic [IDX_W-1:0]     irqIndex
);

  AST_PEND_MASKED: assert property (@(posedge clk) disable iff (!rstN)
    pendWrEn |=> pendOld == (($past(pendOld) & ~$past(pendWrMask)) | ($past(pendWrVal) & $past(pendWrMask)))); // R2

  AST_PEND_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !pendWrEn |=> $stable(pendOld)); // R2

  AST_SEL_PENDING: assert property (@(posedge clk) disable iff (!rstN)
    irqValid |-> ((($past(pendOld) >> irqIndex) & NUM_LINES'(1)) != '0)); // R3

  AST_IDLE_INDEX: assert property (@(posedge clk) disable iff (!rstN)
    !irqValid |-> irqIndex == '0); // R6

  AST_CLAIM_REFUSED: assert property (@(posedge clk) disable iff (!rstN)
    claimFail |-> $stable(claimedOut) && claimDone); // R8

  AST_CLAIM_ADDED: assert property (@(posedge clk) disable iff (!rstN)
    (claimDone && !claimFail) |-> (claimedOut & $past(claimLines)) == $past(claimLines)); // R8

  AST_CLAIM_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    claimReq |=> claimDone); // R8

endmodule

bind irq_sel_top irq_sel_chk #(
  .NUM_LINES(NUM_LINES),
  .IDX_W    (IDX_W)
) uChk (
  .clk       (clk),
  .rstN      (rstN),
  .pendWrEn  (pendWrEn),
  .pendWrMask(pendWrMask),
  .pendWrVal (pendWrVal),
  .pendOld   (pendOld),
  .claimReq  (claimReq),
  .claimLines(claimLines),
  .claimDone (claimDone),
  .claimFail (claimFail),
  .claimedOut(claimedOut),
  .irqValid  (irqValid),
  .irqIndex  (irqIndex)
);

// File: tb/sim_irq_sel_top.sv
`timescale 1ns/1ps
module sim_irq_sel_top;

  localparam int N  = 32;
  localparam int IW = 5;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          pendWrEn = 1'b0;
  logic [N-1:0]  pendWrMask = '0;
  logic [N-1:0]  pendWrVal = '0;
  logic [N-1:0]  pendOld;
  logic          enWrEn = 1'b0;
  logic [N-1:0]  enWrVal = '0;
  logic          delegWrEn = 1'b0;
  logic [N-1:0]  delegWrVal = '0;
  logic [1:0]    privLvl = 2'd3;
  logic          mIe = 1'b0;
  logic          sIe = 1'b0;
  logic          claimReq = 1'b0;
  logic [N-1:0]  claimLines = '0;
  logic          claimDone;
  logic          claimFail;
  logic [N-1:0]  claimedOut;
  logic          irqValid;
  logic [IW-1:0] irqIndex;

  int checks = 0;
  int fails  = 0;
  bit ended  = 0;

  always #4 clk = ~clk;

  irq_sel_top #(.NUM_LINES(N)) u0 (
    .clk(clk), .rstN(rstN),
    .pendWrEn(pendWrEn), .pendWrMask(pendWrMask), .pendWrVal(pendWrVal), .pendOld(pendOld),
    .enWrEn(enWrEn), .enWrVal(enWrVal), .delegWrEn(delegWrEn), .delegWrVal(delegWrVal),
    .privLvl(privLvl), .mIe(mIe), .sIe(sIe),
    .claimReq(claimReq), .claimLines(claimLines), .claimDone(claimDone),
    .claimFail(claimFail), .claimedOut(claimedOut),
    .irqValid(irqValid), .irqIndex(irqIndex)
  );

  typedef struct packed {
    logic [N-1:0] pend;
    logic [N-1:0] en;
    logic [N-1:0] deleg;
    logic [1:0]   priv;
    logic         mie;
    logic         sie;
    logic         expV;
    logic [IW-1:0] expI;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{32'h0000_0880, 32'h0000_0880, 32'h0, 2'd3, 1'b1, 1'b0, 1'b1, 5'd7},  // R4 machine open
    '{32'h0000_0880, 32'h0000_0880, 32'h0, 2'd3, 1'b0, 1'b1, 1'b0, 5'd0},  // R4 machine closed
    '{32'h0000_0880, 32'h0000_0880, 32'h0, 2'd0, 1'b0, 1'b0, 1'b1, 5'd7},  // R4 lower priv
    '{32'h0000_0222, 32'h0000_0222, 32'h0000_0222, 2'd1, 1'b1, 1'b0, 1'b0, 5'd0}, // R5 super closed
    '{32'h0000_0222, 32'h0000_0222, 32'h0000_0222, 2'd1, 1'b0, 1'b1, 1'b1, 5'd1}, // R5 super open
    '{32'h0000_0222, 32'h0000_0222, 32'h0000_0222, 2'd0, 1'b0, 1'b0, 1'b1, 5'd1}, // R5 user
    '{32'h0000_0222, 32'h0000_0222, 32'hFFFF_FFFF, 2'd3, 1'b1, 1'b1, 1'b0, 5'd0}, // R5 machine blocks
    '{32'h0000_0222, 32'h0000_0222, 32'hFFFF_FFFF, 2'd2, 1'b0, 1'b1, 1'b0, 5'd0}, // R5 priv 2
    '{32'hFFFF_0000, 32'h8000_0000, 32'h0, 2'd3, 1'b1, 1'b0, 1'b1, 5'd31}, // R3 top line
    '{32'h0000_00F0, 32'h0000_00E0, 32'h0, 2'd3, 1'b1, 1'b0, 1'b1, 5'd5},  // R3 disabled bit4
    '{32'h0000_0006, 32'h0000_0006, 32'h0000_0002, 2'd3, 1'b1, 1'b1, 1'b1, 5'd2}, // R6 mixed
    '{32'h0000_0006, 32'h0000_0006, 32'h0000_0004, 2'd1, 1'b0, 1'b0, 1'b1, 5'd1}, // R6 mixed super
    '{32'h0000_0001, 32'h0000_0001, 32'h0, 2'd3, 1'b1, 1'b0, 1'b1, 5'd0},  // R6 index 0
    '{32'h0000_0000, 32'hFFFF_FFFF, 32'h0, 2'd0, 1'b1, 1'b1, 1'b0, 5'd0}   // R6 none
  };

  task automatic check(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  // drive at negedge, let one edge apply it, release
  task automatic step();
    @(posedge clk);
    @(negedge clk);
    pendWrEn  = 1'b0;
    enWrEn    = 1'b0;
    delegWrEn = 1'b0;
    claimReq  = 1'b0;
  endtask

  task automatic load_all(input logic [N-1:0] p, input logic [N-1:0] e, input logic [N-1:0] d);
    pendWrEn = 1'b1; pendWrMask = '1; pendWrVal = p;
    enWrEn = 1'b1; enWrVal = e;
    delegWrEn = 1'b1; delegWrVal = d;
    step();
  endtask

  task automatic claim(input logic [N-1:0] lines);
    claimReq = 1'b1; claimLines = lines;
    step();
  endtask

  initial begin
    #1600000;
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset values
    check("R1 pendOld", pendOld, '0);
    check("R1 claimedOut", claimedOut, '0);
    check("R1 irqValid", N'(irqValid), '0);
    check("R1 irqIndex", N'(irqIndex), '0);
    check("R1 claimDone", N'(claimDone), '0);
    rstN = 1'b1;
    @(negedge clk);
    // R1 enable cleared by reset: pending alone selects nothing
    privLvl = 2'd0;
    pendWrEn = 1'b1; pendWrMask = '1; pendWrVal = 32'h8;
    step();
    @(negedge clk);
    check("R1 enable cleared", N'(irqValid), '0);

    // table walk
    for (int k = 0; k < NV; k++) begin
      privLvl = VECS[k].priv; mIe = VECS[k].mie; sIe = VECS[k].sie;
      load_all(VECS[k].pend, VECS[k].en, VECS[k].deleg);
      @(negedge clk);
      check($sformatf("R6 vec%0d valid", k), N'(irqValid), N'(VECS[k].expV));
      check($sformatf("R6 vec%0d index", k), N'(irqIndex), N'(VECS[k].expI));
    end

    // R7 latency: line 0 selected, close machine level
    privLvl = 2'd3; mIe = 1'b1; sIe = 1'b0;
    load_all(32'h1, 32'h1, 32'h0);
    @(negedge clk);
    check("R7 before", N'(irqValid), N'(1));
    mIe = 1'b0;
    check("R7 same cycle", N'(irqValid), N'(1));
    @(negedge clk);
    check("R7 one edge", N'(irqValid), N'(0));
    mIe = 1'b1;
    @(negedge clk);
    check("R7 reopen", N'(irqValid), N'(1));
    // R9 enable word replaced in full
    enWrEn = 1'b1; enWrVal = 32'h0;
    step();
    @(negedge clk);
    check("R9 enable cleared", N'(irqValid), N'(0));
    // R9 delegation word replaced: move line 0 to supervisor
    enWrEn = 1'b1; enWrVal = 32'h1;
    delegWrEn = 1'b1; delegWrVal = 32'h1;
    step();
    @(negedge clk);
    check("R9 delegated blocked", N'(irqValid), N'(0));

    // R2 masked write and returned old value
    load_all(32'hA5A5_0F0F, 32'h0, 32'h0);
    pendWrEn = 1'b1; pendWrMask = 32'h0000_FFFF; pendWrVal = 32'h1234_5678;
    check("R2 old value", pendOld, 32'hA5A5_0F0F);
    step();
    check("R2 merged", pendOld, 32'hA5A5_5678);
    pendWrEn = 1'b1; pendWrMask = 32'h0; pendWrVal = 32'hFFFF_FFFF;
    step();
    check("R2 empty mask", pendOld, 32'hA5A5_5678);
    pendWrVal = 32'h0;
    @(negedge clk);
    check("R2 no write", pendOld, 32'hA5A5_5678);

    // R8 claims
    claim(32'h3);
    check("R8 first done", N'({claimDone, claimFail}), N'(2'b10));
    check("R8 first word", claimedOut, 32'h3);
    claim(32'h6);
    check("R8 clash done", N'({claimDone, claimFail}), N'(2'b11));
    check("R8 clash word", claimedOut, 32'h3);
    claim(32'hC);
    check("R8 third word", claimedOut, 32'hF);
    @(negedge clk);
    check("R8 pulse ends", N'(claimDone), N'(0));

    finish_run();
  end

endmodule